// File: doc/BRIEF.md
# Double Frame Buffer Arbiter

This block decides how a video capture engine and a host reader share a pair of frame buffers. The capture side signals the beginning and the end of each incoming field. The arbiter answers with a capture enable and the index of the buffer that field goes into. When no read is under way, captured fields land in the two buffers in turn. The host asks for a whole frame with a request. It gets a grant pulse and the index of the buffer holding the most recently completed frame, and it keeps that buffer until it signals that the read is done. The host never waits on a capture in progress.

Each buffer has a valid flag and an ordering tag. Starting a capture into a buffer invalidates that buffer. Finishing the capture marks it valid and stamps it with the next tag. While a read is active, capture goes only into the other buffer. Once that other buffer has received a complete frame during the read, all capture stops. Further fields are dropped whole, and capture resumes at the first field start after the read ends. Because of this hold, back-to-back reads always move on to newer data instead of landing on the same old frame again and again.

Top module: `dfb_arbiter`

## Requirements
- R1: While reset is asserted and right after it, cap_en, cap_hold, rd_busy and rd_grant are 0, and cap_sel and rd_sel are 0.
- R2: When fld_start is seen while no capture runs and cap_hold is 0, cap_en is 1 from the next cycle. When fld_done is seen during a capture, cap_en is 0 from the next cycle and that buffer becomes valid.
- R3: With no read active, a capture goes into the buffer that is not the newest valid one: buffer 0 if none is valid, and the older buffer if both are valid. Successive captures therefore alternate.
- R4: When rd_req is seen while idle and some buffer is valid, rd_grant is high for exactly the next cycle. rd_busy rises with it, and rd_sel names the valid buffer with the newest tag. rd_sel stays fixed until rd_busy falls, which happens in the cycle after rd_done is seen.
- R5: A read request made while no buffer is valid gets no grant. If rd_req is still held, the grant comes in the cycle after the first frame becomes valid.
- R6: While rd_busy is 1, a capture never targets the buffer named by rd_sel.
- R7: Once a capture completes during a read, cap_hold is 1 until the read ends. While cap_hold is 1, fld_start starts no capture, so the dropped field changes no buffer.
- R8: After rd_busy falls, cap_hold is 0, and the next fld_start starts a capture. Capture only ever begins at a fld_start, never partway through a field.
- R9: Reads issued one after another, each spanning a completed field, are granted alternate buffers and never repeat the previous read's buffer.
- R10: rd_req while rd_busy is 1 produces no further grant. rd_done while idle has no effect.
- R11: Same-cycle events use the state registered before that edge. rd_req with fld_done grants the buffer that was newest before the completion, and it raises cap_hold in the following cycle. rd_done with fld_start drops that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fld_start | input | 1 | Pulse: a new field begins |
| fld_done | input | 1 | Pulse: the current field has ended |
| rd_req | input | 1 | Host asks for a frame |
| rd_done | input | 1 | Pulse: host has finished reading |
| cap_en | output | 1 | Capture of the current field is enabled |
| cap_sel | output | 1 | Buffer index being captured into |
| cap_hold | output | 1 | Capture is paused behind an active read |
| rd_grant | output | 1 | One-cycle pulse: read accepted |
| rd_busy | output | 1 | A read is active |
| rd_sel | output | 1 | Buffer index the host reads |

## Verification
The contested cycles are a frame completing on the same edge a read is accepted, and a read ending on the same edge a new field starts. The bench drives both coincidences directly. It expects the grant to name the frame that was newest before the edge and the hold to rise right after. It expects the coinciding field to be dropped while the hold clears. A behavioural model built from queues and integers is compared against every output on every cycle. This covers the same timing while continuous capture runs against repeated reads.

// File: rtl/dfb_pkg.sv
package dfb_pkg;
  localparam int unsigned NBUF = 2;
  localparam int unsigned IDX_W = $clog2(NBUF);
  typedef logic [IDX_W-1:0] buf_idx_t;
  typedef enum logic { CAP_IDLE = 1'b0, CAP_RUN = 1'b1 } cap_state_e;
endpackage

// File: rtl/dfb_slot_bank.sv
module dfb_slot_bank
  import dfb_pkg::*;
#(
  parameter int unsigned SEQ_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_en,
  input  buf_idx_t        clr_idx,
  input  logic            fill_en,
  input  buf_idx_t        fill_idx,
  output logic [NBUF-1:0] slot_valid,
  output buf_idx_t        newest_idx,
  output logic            any_valid
);
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic [SEQ_W-1:0] tag_arr [NBUF];
  logic [SEQ_W-1:0] tag_diff;
  logic             second_newer;

  generate
    for (genvar g = 0; g < NBUF; g++) begin : g_slot
      logic             v_q, v_d;
      logic [SEQ_W-1:0] t_q, t_d;
      logic             hit_fill, hit_clr, upd;

      always_comb begin
        hit_fill = fill_en && (fill_idx == buf_idx_t'(g));
        hit_clr  = clr_en && (clr_idx == buf_idx_t'(g));
        upd      = hit_fill || hit_clr;
        v_d      = v_q;
        t_d      = t_q;
        if (hit_fill) begin
          v_d = 1'b1;
          t_d = seq_q;
        end else if (hit_clr) begin
          v_d = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          t_q <= '0;
        end else if (upd) begin
          v_q <= v_d;
          t_q <= t_d;
        end
      end

      assign slot_valid[g] = v_q;
      assign tag_arr[g]    = t_q;

      a_r2_fill_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && fill_idx == buf_idx_t'(g)) |=> v_q);
    end
  endgenerate

  always_comb begin
    seq_d = seq_q + SEQ_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_q <= '0;
    else if (fill_en) seq_q <= seq_d;
  end

  always_comb begin
    tag_diff     = tag_arr[1] - tag_arr[0];
    second_newer = (tag_diff != '0) && !tag_diff[SEQ_W-1];
    any_valid    = |slot_valid;
    if (&slot_valid) newest_idx = buf_idx_t'(second_newer);
    else             newest_idx = buf_idx_t'(slot_valid[1]);
  end

  a_r2_clear_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !fill_en && clr_idx == '0) |=> !slot_valid[0]);
endmodule

// File: rtl/dfb_read_ctrl.sv
module dfb_read_ctrl
  import dfb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rd_req,
  input  logic     rd_done,
  input  logic     any_valid,
  input  buf_idx_t newest_idx,
  output logic     rd_busy,
  output logic     rd_busy_nxt,
  output buf_idx_t rd_sel,
  output logic     rd_grant
);
  logic     busy_q, busy_d;
  buf_idx_t sel_q;
  logic     grant_q;
  logic     accept;

  always_comb begin
    accept = !busy_q && rd_req && any_valid;
    busy_d = accept || (busy_q && !rd_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      grant_q <= 1'b0;
      sel_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      grant_q <= accept;
      if (accept) sel_q <= newest_idx;
    end
  end

  assign rd_busy     = busy_q;
  assign rd_busy_nxt = busy_d;
  assign rd_sel      = sel_q;
  assign rd_grant    = grant_q;

  a_r4_grant_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant |=> !rd_grant);
  a_r4_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && !rd_grant) |-> $stable(rd_sel));
  a_r5_grant_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant |-> (rd_busy && $past(any_valid)));
  a_r10_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && !rd_done) |=> !rd_grant);
endmodule

// File: rtl/dfb_write_ctrl.sv
module dfb_write_ctrl
  import dfb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fld_start,
  input  logic     fld_done,
  input  logic     rd_busy,
  input  logic     rd_busy_nxt,
  input  buf_idx_t rd_sel,
  input  logic     any_valid,
  input  buf_idx_t newest_idx,
  output logic     cap_en,
  output buf_idx_t cap_sel,
  output logic     cap_hold,
  output logic     clr_en,
  output buf_idx_t clr_idx,
  output logic     fill_en,
  output buf_idx_t fill_idx
);
  cap_state_e state_q, state_d;
  buf_idx_t   sel_q, target;
  logic       fresh_q, fresh_d;
  logic       hold, start, finish;

  always_comb begin
    hold   = rd_busy && fresh_q;
    start  = (state_q == CAP_IDLE) && fld_start && !hold;
    finish = (state_q == CAP_RUN) && fld_done;
    if (rd_busy)        target = ~rd_sel;
    else if (any_valid) target = ~newest_idx;
    else                target = '0;
    state_d = state_q;
    if (start)  state_d = CAP_RUN;
    if (finish) state_d = CAP_IDLE;
    fresh_d = rd_busy_nxt && (fresh_q || finish);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAP_IDLE;
      sel_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fresh_q <= fresh_d;
      if (start) sel_q <= target;
    end
  end

  assign cap_en   = (state_q == CAP_RUN);
  assign cap_sel  = sel_q;
  assign cap_hold = hold;
  assign clr_en   = start;
  assign clr_idx  = target;
  assign fill_en  = finish;
  assign fill_idx = sel_q;

  a_r6_no_write_into_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && cap_en) |-> (cap_sel != rd_sel));
  a_r7_hold_blocks_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_hold && !cap_en) |=> !cap_en);
  a_r7_hold_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hold |-> !cap_en);
  a_r8_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_busy) |-> !cap_hold);
  a_r2_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && fld_done) |=> !cap_en);
endmodule

// File: rtl/dfb_arbiter.sv
module dfb_arbiter
  import dfb_pkg::*;
#(
  parameter int unsigned SEQ_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fld_start,
  input  logic fld_done,
  input  logic rd_req,
  input  logic rd_done,
  output logic cap_en,
  output logic cap_sel,
  output logic cap_hold,
  output logic rd_grant,
  output logic rd_busy,
  output logic rd_sel
);
  logic [NBUF-1:0] slot_valid;
  buf_idx_t        newest_idx, clr_idx, fill_idx, rd_sel_i, cap_sel_i;
  logic            any_valid, clr_en, fill_en, rd_busy_nxt;

  dfb_slot_bank #(.SEQ_W(SEQ_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_en     (clr_en),
    .clr_idx    (clr_idx),
    .fill_en    (fill_en),
    .fill_idx   (fill_idx),
    .slot_valid (slot_valid),
    .newest_idx (newest_idx),
    .any_valid  (any_valid)
  );

  dfb_read_ctrl u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_req      (rd_req),
    .rd_done     (rd_done),
    .any_valid   (any_valid),
    .newest_idx  (newest_idx),
    .rd_busy     (rd_busy),
    .rd_busy_nxt (rd_busy_nxt),
    .rd_sel      (rd_sel_i),
    .rd_grant    (rd_grant)
  );

  dfb_write_ctrl u_wr (
    .clk         (clk),
    .rst_n       (rst_n),
    .fld_start   (fld_start),
    .fld_done    (fld_done),
    .rd_busy     (rd_busy),
    .rd_busy_nxt (rd_busy_nxt),
    .rd_sel      (rd_sel_i),
    .any_valid   (any_valid),
    .newest_idx  (newest_idx),
    .cap_en      (cap_en),
    .cap_sel     (cap_sel_i),
    .cap_hold    (cap_hold),
    .clr_en      (clr_en),
    .clr_idx     (clr_idx),
    .fill_en     (fill_en),
    .fill_idx    (fill_idx)
  );

  assign rd_sel  = rd_sel_i[0];
  assign cap_sel = cap_sel_i[0];

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!cap_en && !rd_busy && !rd_grant));
endmodule

// File: tb/dfb_arbiter_tb.sv
`timescale 1ns/100ps
module dfb_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fld_start = 1'b0, fld_done = 1'b0, rd_req = 1'b0, rd_done = 1'b0;
  logic cap_en, cap_sel, cap_hold, rd_grant, rd_busy, rd_sel;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int grant_count = 0;
  int cap_starts[$];
  logic prev_cap = 1'b0;

  int m_v[2], m_tag[2];
  int m_seq, m_cap, m_cb, m_busy, m_rsel, m_fresh, m_grant;

  always #2.5 clk = ~clk;

  dfb_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .fld_start(fld_start), .fld_done(fld_done),
    .rd_req(rd_req), .rd_done(rd_done), .cap_en(cap_en), .cap_sel(cap_sel),
    .cap_hold(cap_hold), .rd_grant(rd_grant), .rd_busy(rd_busy), .rd_sel(rd_sel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_v[0] = 0; m_v[1] = 0; m_tag[0] = 0; m_tag[1] = 0;
      m_seq = 0; m_cap = 0; m_cb = 0; m_busy = 0; m_rsel = 0; m_fresh = 0; m_grant = 0;
    end else begin
      int any, newest, hold, done_now, nbusy;
      any = m_v[0] | m_v[1];
      if (m_v[0] && m_v[1]) newest = (m_tag[1] > m_tag[0]) ? 1 : 0;
      else newest = m_v[1] ? 1 : 0;
      hold = m_busy & m_fresh;
      done_now = 0;
      nbusy = m_busy;
      m_grant = 0;
      if (!m_busy && rd_req && any) begin
        nbusy = 1; m_grant = 1;
      end else if (m_busy && rd_done) nbusy = 0;
      if (m_cap) begin
        if (fld_done) begin
          m_cap = 0; m_v[m_cb] = 1; m_tag[m_cb] = m_seq; m_seq++; done_now = 1;
        end
      end else if (fld_start && !hold) begin
        m_cap = 1;
        m_cb = m_busy ? 1 - m_rsel : (any ? 1 - newest : 0);
        m_v[m_cb] = 0;
      end
      if (m_grant) m_rsel = newest;
      m_fresh = nbusy & (m_fresh | done_now);
      m_busy = nbusy;
    end
  end

  always @(negedge clk) begin
    chk("R2 cap_en", cap_en, m_cap);
    chk("R6 cap_sel", cap_sel, m_cb);
    chk("R7 cap_hold", cap_hold, m_busy & m_fresh);
    chk("R4 rd_grant", rd_grant, m_grant);
    chk("R4 rd_busy", rd_busy, m_busy);
    chk("R4 rd_sel", rd_sel, m_rsel);
    if (rd_grant) grant_count++;
    if (cap_en && !prev_cap) cap_starts.push_back(cap_sel);
    prev_cap = cap_en;
  end

  task automatic drive(input logic fs, input logic fd, input logic rq, input logic rdn);
    @(posedge clk);
    #1;
    fld_start = fs; fld_done = fd; rd_req = rq; rd_done = rdn;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0);
  endtask

  task automatic field(input int len);
    drive(1, 0, 0, 0);
    for (int i = 0; i < len; i++) drive(0, 0, 0, 0);
    drive(0, 1, 0, 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int ncap, g0, prev;
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 cap_en", cap_en, 0); chk("R1 cap_hold", cap_hold, 0);
    chk("R1 rd_busy", rd_busy, 0); chk("R1 rd_grant", rd_grant, 0);
    chk("R1 rd_sel", rd_sel, 0); chk("R1 cap_sel", cap_sel, 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 after release busy", rd_busy, 0);

    // R5: request before any frame is held off
    for (int i = 0; i < 4; i++) drive(0, 0, 1, 0);
    chk("R5 no early grant", grant_count, 0);
    chk("R5 no early busy", rd_busy, 0);
    drive(1, 0, 1, 0);
    drive(0, 0, 1, 0);
    chk("R2 capture started", cap_en, 1);
    chk("R3 first buffer", cap_sel, 0);
    drive(0, 0, 1, 0);
    drive(0, 1, 1, 0);
    drive(0, 0, 1, 0);
    chk("R2 capture ended", cap_en, 0);
    chk("R5 still no grant", grant_count, 0);
    drive(0, 0, 0, 0);
    chk("R5 grant after first frame", rd_grant, 1);
    chk("R4 grant on newest", rd_sel, 0);
    idle(1);
    chk("R4 grant one cycle", rd_grant, 0);

    // R6, R7: capture during read goes to other buffer, then holds
    drive(1, 0, 0, 0);
    drive(0, 0, 0, 0);
    chk("R6 capture avoids read buffer", cap_sel, 1);
    drive(0, 1, 0, 0);
    drive(0, 0, 0, 0);
    chk("R7 hold raised", cap_hold, 1);
    ncap = cap_starts.size();
    drive(1, 0, 0, 0);
    idle(3);
    chk("R7 field dropped", cap_en, 0);
    chk("R7 no capture start", cap_starts.size(), ncap);
    chk("R7 read buffer kept", rd_sel, 0);

    // R11: rd_done with fld_start drops that field; R8 resume
    drive(1, 0, 0, 1);
    drive(0, 0, 0, 0);
    chk("R11 field dropped on release", cap_en, 0);
    chk("R8 hold cleared", cap_hold, 0);
    chk("R8 busy cleared", rd_busy, 0);
    drive(1, 0, 0, 0);
    drive(0, 0, 0, 0);
    chk("R8 capture resumes", cap_en, 1);
    chk("R3 older buffer chosen", cap_sel, 0);
    drive(0, 1, 0, 0);
    idle(2);

    // R11: rd_req with fld_done in the same cycle
    drive(1, 0, 0, 0);
    drive(0, 0, 0, 0);
    chk("R3 alternate capture", cap_sel, 1);
    drive(0, 1, 1, 0);
    drive(0, 0, 0, 0);
    chk("R11 grant on prior newest", rd_sel, 0);
    chk("R11 grant pulse", rd_grant, 1);
    chk("R11 hold next cycle", cap_hold, 1);
    drive(0, 0, 0, 1);
    idle(2);

    // R9: repeated reads during continuous capture
    prev = -1;
    for (int k = 0; k < 6; k++) begin
      drive(0, 0, 1, 0);
      drive(0, 0, 0, 0);
      g0 = rd_sel;
      if (prev >= 0) chk("R9 read moves to other buffer", g0, 1 - prev);
      prev = g0;
      field(3);
      idle(2);
      drive(0, 0, 0, 1);
      idle(1);
    end

    // R10: stray rd_done while idle, rd_req while busy
    drive(0, 0, 0, 1);
    drive(0, 0, 0, 0);
    chk("R10 stray done ignored", rd_busy, 0);
    ncap = grant_count;
    drive(0, 0, 1, 0);
    for (int i = 0; i < 4; i++) drive(0, 0, 1, 0);
    drive(0, 0, 0, 0);
    chk("R10 single grant while busy", grant_count, ncap + 1);
    chk("R10 still busy", rd_busy, 1);
    drive(0, 0, 0, 1);
    idle(3);
    finish_run();
  end
endmodule